// File: doc/BRIEF.md
# Differential Sample Decoder

This block rebuilds a stream of unsigned 8-bit audio samples from 4-bit differential codes. It holds one running value, the predictor. Each accepted code maps to a signed power-of-two step, and the block adds that step to the predictor. The sum is both the sample it outputs and the base for the next code. A matching encoder keeps the same predictor internally, so the decoder's output follows the encoder's reconstruction exactly, sample for sample.

Codes arrive over a valid/ready handshake, one per cycle at most. The new sample appears one cycle after its code is taken, and a one-cycle strobe marks it. The sample then holds until the next code is taken. A synchronous restart input returns the predictor to mid-scale at the start of each playback.

Top module: `dpcm_dec`

## Requirements
- R1: After reset, sample_o is 0x80, sample_valid_o is 0 and code_ready_o is 1.
- R2: While restart_i is high, code_ready_o is 0 and no code is consumed. On the cycle after restart_i is high, sample_o is 0x80 and sample_valid_o is 0.
- R3: Codes 0 and 8 leave the sample unchanged.
- R4: Codes 1 to 7 subtract 64, 32, 16, 8, 4, 2 and 1, in that code order.
- R5: Codes 9 to 15 add 1, 2, 4, 8, 16, 32 and 64, in that code order.
- R6: A code is taken at a rising edge when code_valid_i and code_ready_o are both high. The new sample is on sample_o after that edge, and sample_valid_o is high for exactly that one cycle.
- R7: When no code is taken, sample_o holds its value and sample_valid_o is 0.
- R8: If a step would move the result below 0, the result clamps to 0. If it would move the result above 255, the result clamps to 255.
- R9: Starting from 0x80, the codes 12, 7, 10, 10, 5, 4, 3 produce 136, 135, 137, 139, 135, 127, 111.
- R10: Driven by a matching encoder from the same start value, the decoder output equals the encoder's predictor after every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous rewind of the predictor to mid-scale |
| code_valid_i | input | 1 | A code is offered |
| code_i | input | 4 | Differential code |
| code_ready_o | output | 1 | Code can be taken this cycle |
| sample_o | output | 8 | Reconstructed sample, which is also the predictor |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample |

## Verification
The assertions assume that code_i is stable and known whenever code_valid_i is high. They also assume that restart_i is a clean synchronous level. The bench drives every input at the falling clock edge and raises code_valid_i only with a defined code, so both assumptions hold. The saturation checks on direction assume that the handshake is the only thing that changes the predictor. The bench keeps to this by issuing restarts only on cycles it treats as restarts, and never as codes.

// File: rtl/dpcm_pkg.sv
package dpcm_pkg;
  // signed step for one code: MSB set = positive, low bits = magnitude index
  function automatic int step_of(input int code, input int code_w);
    int nlev;
    int m;
    nlev = 1 << (code_w - 1);
    m    = code % nlev;
    if (m == 0) return 0;
    if (code >= nlev) return 1 << (m - 1);
    return -(1 << (nlev - 1 - m));
  endfunction
endpackage

// File: rtl/dpcm_step_lut.sv
module dpcm_step_lut #(
  parameter int CODE_W = 4,
  parameter int DIFF_W = 8
) (
  input  logic        [CODE_W-1:0] code_i,
  output logic signed [DIFF_W-1:0] diff_o
);
  localparam int NCODE = 1 << CODE_W;

  logic signed [DIFF_W-1:0] tbl [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_tbl
    assign tbl[g] = DIFF_W'(dpcm_pkg::step_of(g, CODE_W));
  end

  assign diff_o = tbl[code_i];
endmodule

// File: rtl/dpcm_sat_add.sv
module dpcm_sat_add #(
  parameter int SAMPLE_W = 8,
  parameter int DIFF_W   = 8
) (
  input  logic        [SAMPLE_W-1:0] pred_i,
  input  logic signed [DIFF_W-1:0]   diff_i,
  output logic        [SAMPLE_W-1:0] sum_o
);
  localparam int SUM_W = ((SAMPLE_W > DIFF_W) ? SAMPLE_W : DIFF_W) + 2;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << SAMPLE_W) - 1);

  logic signed [SUM_W-1:0] pred_w;
  logic signed [SUM_W-1:0] diff_w;
  logic signed [SUM_W-1:0] wide;

  assign pred_w = $signed({{(SUM_W-SAMPLE_W){1'b0}}, pred_i});
  assign diff_w = SUM_W'(diff_i);
  assign wide   = pred_w + diff_w;

  always_comb begin
    if (wide < 0)          sum_o = '0;
    else if (wide > MAXV)  sum_o = '1;
    else                   sum_o = wide[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/dpcm_dec.sv
module dpcm_dec #(
  parameter int CODE_W   = 4,
  parameter int SAMPLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic                code_valid_i,
  input  logic [CODE_W-1:0]   code_i,
  output logic                code_ready_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_valid_o
);
  localparam int NLEV = 1 << (CODE_W - 1);
  localparam int DIFF_W = NLEV;
  localparam logic [SAMPLE_W-1:0] INIT = SAMPLE_W'(1 << (SAMPLE_W - 1));

  logic                     accept;
  logic signed [DIFF_W-1:0] diff;
  logic [SAMPLE_W-1:0]      pred_q;
  logic [SAMPLE_W-1:0]      pred_d;
  logic                     vld_q;

  assign code_ready_o = !restart_i;  // restart wins over a pending code
  assign accept       = code_valid_i && code_ready_o;

  dpcm_step_lut #(.CODE_W(CODE_W), .DIFF_W(DIFF_W)) u_lut (
    .code_i (code_i),
    .diff_o (diff)
  );

  dpcm_sat_add #(.SAMPLE_W(SAMPLE_W), .DIFF_W(DIFF_W)) u_add (
    .pred_i (pred_q),
    .diff_i (diff),
    .sum_o  (pred_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q <= INIT;
      vld_q  <= 1'b0;
    end else if (restart_i) begin
      pred_q <= INIT;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= accept;
      if (accept) pred_q <= pred_d;
    end
  end

  assign sample_o       = pred_q;
  assign sample_valid_o = vld_q;

  a_r2_restart_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (sample_o == INIT) && !sample_valid_o);

  a_r2_restart_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> !code_ready_o);

  a_r6_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_valid_i && code_ready_o) |=> sample_valid_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(code_valid_i && code_ready_o) && !restart_i) |=> $stable(sample_o) && !sample_valid_o);

  a_r3_zero_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_valid_i && !restart_i && code_i[CODE_W-2:0] == '0) |=> $stable(sample_o));

  a_r8_up_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_valid_i && !restart_i && code_i[CODE_W-1]) |=> sample_o >= $past(sample_o));

  a_r8_down_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_valid_i && !restart_i && !code_i[CODE_W-1]) |=> sample_o <= $past(sample_o));
endmodule

// File: tb/sim_dpcm_dec.sv
module sim_dpcm_dec;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       restart_i = 1'b0;
  logic       code_valid_i = 1'b0;
  logic [3:0] code_i = '0;
  logic       code_ready_o;
  logic [7:0] sample_o;
  logic       sample_valid_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;

  dpcm_dec u0 (
    .clk_i, .rst_ni, .restart_i, .code_valid_i, .code_i,
    .code_ready_o, .sample_o, .sample_valid_o
  );

  // {code, expected sample} walked from 0x80 (R9 first seven, then R3/R4/R5)
  localparam int NV = 17;
  localparam logic [11:0] VEC [NV] = '{
    {4'd12, 8'd136}, {4'd7, 8'd135}, {4'd10, 8'd137}, {4'd10, 8'd139},
    {4'd5, 8'd135},  {4'd4, 8'd127}, {4'd3, 8'd111},  {4'd5, 8'd107},
    {4'd11, 8'd111}, {4'd10, 8'd113}, {4'd0, 8'd113}, {4'd6, 8'd111},
    {4'd9, 8'd112},  {4'd8, 8'd112}, {4'd13, 8'd128}, {4'd14, 8'd160},
    {4'd2, 8'd128}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench-side step table, from the requirement text
  function automatic int step(input int c);
    case (c)
      1: return -64; 2: return -32; 3: return -16; 4: return -8;
      5: return -4;  6: return -2;  7: return -1;
      9: return 1;   10: return 2;  11: return 4;  12: return 8;
      13: return 16; 14: return 32; 15: return 64;
      default: return 0;
    endcase
  endfunction

  // encoder: largest power-of-two step not exceeding |difference|
  function automatic int encode(input int s, input int p);
    int d;
    int mag;
    int k;
    d = s - p;
    mag = (d < 0) ? -d : d;
    if (mag == 0) return 0;
    k = 0;
    while (k < 6 && (2 << k) <= mag) k++;
    return (d > 0) ? 9 + k : 7 - k;
  endfunction

  // offer one code; on return, sample is half a cycle past the accept edge
  task automatic send(input int c);
    @(negedge clk_i);
    code_valid_i = 1'b1;
    code_i = 4'(c);
    @(negedge clk_i);
    code_valid_i = 1'b0;
  endtask

  task automatic do_restart();
    @(negedge clk_i);
    restart_i = 1'b1;
    @(negedge clk_i);
    restart_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pred;
    int exp;
    int hold;
    #12;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(sample_o == 8'h80, "R1 reset sample", sample_o, 128);
    check(!sample_valid_o, "R1 reset valid", sample_valid_o, 0);
    check(code_ready_o, "R1 reset ready", code_ready_o, 1);

    // vector walk: R9, R3, R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      send(int'(VEC[i][11:8]));
      check(sample_o == VEC[i][7:0], "R9/R3/R4/R5 vector", sample_o, VEC[i][7:0]);
      check(sample_valid_o, "R6 strobe", sample_valid_o, 1);
    end

    // R7 hold while the code changes with valid low
    hold = sample_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      code_i = 4'(15 - i);
      check(sample_o == 8'(hold), "R7 hold", sample_o, hold);
      check(!sample_valid_o, "R7 no strobe", sample_valid_o, 0);
    end

    // R2 restart with a code offered at the same time
    @(negedge clk_i);
    restart_i = 1'b1;
    code_valid_i = 1'b1;
    code_i = 4'd15;
    #0.1;
    check(!code_ready_o, "R2 ready low", code_ready_o, 0);
    @(negedge clk_i);
    restart_i = 1'b0;
    code_valid_i = 1'b0;
    check(sample_o == 8'h80, "R2 restart value", sample_o, 128);
    check(!sample_valid_o, "R2 restart no strobe", sample_valid_o, 0);

    // R4/R5 every code step from mid-scale
    for (int c = 0; c < 16; c++) begin
      do_restart();
      send(c);
      check(int'(sample_o) == 128 + step(c), "R4/R5 single step", sample_o, 128 + step(c));
    end

    // R8 clamp high then low
    do_restart();
    send(15); send(15);
    check(sample_o == 8'd255, "R8 clamp high", sample_o, 255);
    send(15);
    check(sample_o == 8'd255, "R8 stay high", sample_o, 255);
    send(1); send(1); send(1); send(1);
    check(sample_o == 8'd0, "R8 clamp low", sample_o, 0);
    send(7);
    check(sample_o == 8'd0, "R8 stay low", sample_o, 0);

    // R10 encoder chain: ramp up/down then random
    do_restart();
    pred = 128;
    for (int i = 0; i < 200; i++) begin
      int s;
      int c;
      s = (i < 100) ? (i * 5) % 256 : 255 - ((i - 100) * 3) % 256;
      c = encode(s, pred);
      exp = pred + step(c);
      pred = exp;
      send(c);
      check(int'(sample_o) == exp, "R10 ramp track", sample_o, exp);
    end
    do_restart();
    pred = 128;
    for (int i = 0; i < 400; i++) begin
      int s;
      int c;
      s = int'($urandom_range(255, 0));
      c = encode(s, pred);
      exp = pred + step(c);
      pred = exp;
      send(c);
      check(int'(sample_o) == exp, "R10 random track", sample_o, exp);
    end

    // R1 asynchronous reset mid-stream
    send(14);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(sample_o == 8'h80, "R1 async reset", sample_o, 128);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule